// File: doc/BRIEF.md
# Codec Control Register Slave on a Two-Wire Bus

This block is the control port of an audio codec. It sits on a standard two-wire bus at up to 100 kHz. It oversamples SCL and SDA with the system clock and keeps the codec's 8-bit control registers at addresses 00h to 14h. A host addresses the device and sends a register pointer. The host then either streams data bytes into consecutive registers or restarts the bus and reads consecutive registers back. All writable register contents are brought out as one flat bus that drives the rest of the codec.

Three features go beyond a plain register slave. A write of any value to register 00h restores every register to its default and drops the bus engine back to idle. A strap pin supplies one bit of the device address. The device address is itself register 14h, and it can only be rewritten directly after an unlock key has been placed in register 13h. The slave never stretches the clock and only uses 7-bit addressing.

Top module: `codec_i2c_regs`

## Requirements
- R1: After a START, the slave ACKs an address byte only when its bits 7:1 equal bits 7:1 of register 14h. A byte that does not match gets no ACK, and the slave ignores the bus until the next START.
- R2: In a write (address bit 0 = 0), the next byte is the register pointer and is ACKed. Each following byte is stored in the pointed register, ACKed, and the pointer then advances by one.
- R3: A STOP ends a burst. A new transaction loads a fresh pointer, and every register keeps the value last written to it.
- R4: After hard reset, registers 02h–0Ah hold 80h, register 0Fh holds 10h, register 14h holds 54h with bit 1 replaced by the strap pin, and all other registers hold 00h.
- R5: A data byte aimed at register 00h restores every register to its R4 default, using the strap pin's present value. That byte gets no ACK, and the bytes after it are ignored until the next START.
- R6: Register 0Bh, 12h and 13h always read 00h. Registers 09h and 0Ah keep only bits 7 and 3:0. Register 0Dh keeps bits 7, 6 and 4. Registers 0Eh, 0Fh and 10h keep bits 4:0. Bit 0 of 14h stays 0. All other bits of 02h–11h are kept.
- R7: A repeated START followed by a read address (bit 0 = 1) returns bytes MSB first, starting at the current pointer, and the pointer advances after each byte. Register 00h reads the 3-bit section status in bits 2:0, and register 01h reads the 8-bit channel status. A master NACK ends the read and releases SDA.
- R8: The pointer stops at 15h. Data aimed at a pointer of 15h or above gets no ACK and changes nothing, and reads there return 00h.
- R9: A write to 14h takes effect only if the register write just before it, in the same or an earlier transaction, stored ABh to 13h. That unlock is used up by the 14h write and cleared by a write to any other register. After the change, the new address is the one that is matched.
- R10: The slave starts pulling SDA low only while SCL is low, and after a STOP or a completed read SDA is released.
- R11: `regs_o` bits [8k+7:8k] carry register k for k = 0 to 20. Registers 00h and 01h appear there as 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low (open drain) |
| cs_pin | input | 1 | Strap pin that sets address bit 1 on reset |
| stat_sys | input | 3 | Section status returned when reading 00h |
| stat_ch | input | 8 | Channel status returned when reading 01h |
| regs_o | output | 8*NREG | Register contents, register k in byte k |

## Verification
The bound checker watches on every cycle that SDA is never first pulled low while SCL is high, that SDA is free whenever the engine is idle, and that the device address changes only after an unlock or a soft reset. It also checks that a pointer beyond the map leaves every register untouched. Address matching, auto-increment across bursts, the bit masks, the status read-back, soft reset in the middle of a burst, and the unlock being consumed or cancelled are shown only by the bench's transactions, which compare ACKs, read data and the register bus against a model built from the requirements.

// File: rtl/codec_i2c_regs.sv
module codec_i2c_regs #(
  parameter int         NREG      = 21,
  parameter int         SYNC      = 2,
  parameter logic [7:0] KEY       = 8'hAB,
  parameter logic [7:0] BASE_ADDR = 8'h54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              cs_pin,
  input  logic [2:0]        stat_sys,
  input  logic [7:0]        stat_ch,
  output logic [8*NREG-1:0] regs_o
);
  localparam int         IW   = $clog2(NREG);
  localparam int         AREG = NREG - 1;
  localparam int         CREG = NREG - 2;
  localparam logic [7:0] PEND = 8'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK, S_MACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_t;

  st_t             st;
  kind_t           kind;
  logic            rw, unlock;
  logic [7:0]      sh, ptr, rd;
  logic [3:0]      bcnt;
  logic [7:0]      rf [NREG];
  logic [SYNC-1:0] scl_sh, sda_sh;
  logic            scl_q, sda_q;
  logic            scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

  assign scl_s    = scl_sh[SYNC-1];
  assign sda_s    = sda_sh[SYNC-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign sda_oe   = (st == S_ACK) | ((st == S_TX) & ~sh[7]);

  function automatic logic [7:0] defval(int i, logic cs);
    if (i >= 2 && i <= 10) return 8'h80;
    if (i == 15)           return 8'h10;
    if (i == AREG)         return BASE_ADDR | {6'b0, cs, 1'b0};
    return 8'h00;
  endfunction

  function automatic logic [7:0] wmask(int i);
    case (i)
      2, 3, 4, 5, 6, 7, 8, 12, 17: return 8'hFF;
      9, 10:                       return 8'h8F;
      13:                          return 8'hD0;
      14, 15, 16:                  return 8'h1F;
      default:                     return (i == AREG) ? 8'hFE : 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] nxt(logic [7:0] p);
    return (p < PEND) ? p + 8'd1 : p;
  endfunction

  always_comb begin
    if (ptr == 8'd0)      rd = {5'b0, stat_sys};
    else if (ptr == 8'd1) rd = stat_ch;
    else if (ptr < PEND)  rd = rf[ptr[IW-1:0]];
    else                  rd = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      st     <= S_IDLE;
      kind   <= K_ADDR;
      rw     <= 1'b0;
      sh     <= 8'h00;
      ptr    <= 8'h00;
      bcnt   <= 4'd0;
      unlock <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= defval(i, cs_pin);
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      if (start_c) begin
        st   <= S_RX;
        kind <= K_ADDR;
        bcnt <= 4'd0;
      end else if (stop_c) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_s};
              bcnt <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == 4'd8) begin
              case (kind)
                K_ADDR: begin
                  if (sh[7:1] == rf[AREG][7:1]) begin
                    rw <= sh[0];
                    st <= S_ACK;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                K_PTR: begin
                  ptr  <= sh;
                  kind <= K_DATA;
                  st   <= S_ACK;
                end
                default: begin
                  if (ptr == 8'd0) begin
                    for (int i = 0; i < NREG; i++) rf[i] <= defval(i, cs_pin);
                    unlock <= 1'b0;
                    ptr    <= 8'd0;
                    st     <= S_IDLE;
                  end else if (ptr < PEND) begin
                    if (int'(ptr) == AREG) begin
                      if (unlock) rf[AREG] <= sh & wmask(AREG);
                      unlock <= 1'b0;
                    end else begin
                      rf[ptr[IW-1:0]] <= sh & wmask(int'(ptr));
                      unlock <= (int'(ptr) == CREG) && (sh == KEY);
                    end
                    ptr <= nxt(ptr);
                    st  <= S_ACK;
                  end else begin
                    st <= S_IDLE;
                  end
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              bcnt <= 4'd0;
              if (kind == K_ADDR && rw) begin
                sh  <= rd;
                ptr <= nxt(ptr);
                st  <= S_TX;
              end else begin
                if (kind == K_ADDR) kind <= K_PTR;
                st <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bcnt == 4'd7) begin
                st <= S_RACK;
              end else begin
                sh   <= {sh[6:0], 1'b0};
                bcnt <= bcnt + 4'd1;
              end
            end
          end
          S_RACK: begin
            if (scl_rise) st <= sda_s ? S_IDLE : S_MACK;
          end
          S_MACK: begin
            if (scl_fall) begin
              sh   <= rd;
              ptr  <= nxt(ptr);
              bcnt <= 4'd0;
              st   <= S_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[8*g +: 8] = rf[g];
  end
endmodule

// File: rtl/codec_i2c_regs_chk.sv
module codec_i2c_regs_chk #(
  parameter int NREG = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_s,
  input logic              idle,
  input logic              unlock,
  input logic [7:0]        ptr,
  input logic [7:0]        addr,
  input logic [8*NREG-1:0] regs
);
  a_r10_pull_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !$past(sda_oe)) |-> !scl_s);

  a_r7_idle_releases: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);

  a_r9_addr_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr) |-> ($past(unlock) || $past(ptr) == 8'd0));

  a_r8_no_write_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr >= 8'(NREG)) |=> $stable(regs));
endmodule

bind codec_i2c_regs codec_i2c_regs_chk #(.NREG(NREG)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .sda_oe (sda_oe),
  .scl_s  (scl_s),
  .idle   (st == S_IDLE),
  .unlock (unlock),
  .ptr    (ptr),
  .addr   (rf[NREG-1]),
  .regs   (regs_o)
);

// File: tb/sim_codec_i2c_regs.sv
`timescale 1ns/1ps
module sim_codec_i2c_regs;
  localparam int NREG = 21;
  localparam int Q    = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, cs_pin = 1'b1;
  logic [2:0] stat_sys = 3'd0;
  logic [7:0] stat_ch = 8'd0;
  logic sda_oe;
  logic [8*NREG-1:0] regs_o;
  wire sda = ~(m_low | sda_oe);

  always #2.5 clk = ~clk;

  codec_i2c_regs u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .cs_pin(cs_pin), .stat_sys(stat_sys), .stat_ch(stat_ch), .regs_o(regs_o)
  );

  int checks = 0, errs = 0;
  bit done = 1'b0;
  logic [7:0] em [NREG];
  logic [7:0] ep;
  bit eu;
  logic [7:0] wbuf [8];

  function automatic logic [7:0] bdef(int i, logic cs);
    if (i >= 2 && i <= 10) return 8'h80;
    if (i == 15) return 8'h10;
    if (i == 20) return 8'h54 | {6'b0, cs, 1'b0};
    return 8'h00;
  endfunction

  function automatic logic [7:0] bmask(int i);
    if (i == 9 || i == 10) return 8'h8F;
    if (i == 13) return 8'hD0;
    if (i >= 14 && i <= 16) return 8'h1F;
    if (i == 20) return 8'hFE;
    if (i == 0 || i == 1 || i == 11 || i == 18 || i == 19) return 8'h00;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] mread(logic [7:0] p);
    if (p == 8'd0) return {5'b0, stat_sys};
    if (p == 8'd1) return stat_ch;
    if (p < 8'd21) return em[p];
    return 8'h00;
  endfunction

  function automatic logic [7:0] pinc(logic [7:0] p);
    return (p < 8'd21) ? p + 8'd1 : p;
  endfunction

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset(input logic cs);
    for (int i = 0; i < NREG; i++) em[i] = bdef(i, cs);
    eu = 1'b0;
    ep = 8'd0;
  endtask

  task automatic model_wr(input logic [7:0] p, input logic [7:0] d);
    if (p == 8'd20) begin
      if (eu) em[20] = d & 8'hFE;
      eu = 1'b0;
    end else begin
      em[p] = d & bmask(int'(p));
      eu = (p == 8'd19) && (d == 8'hAB);
    end
  endtask

  task automatic hard_reset(input logic cs);
    cs_pin = cs;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    model_reset(cs);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_map(input string tag);
    for (int i = 0; i < NREG; i++) chk(tag, regs_o[8*i +: 8], em[i]);
  endtask

  task automatic i2c_start;
    m_low = 1'b0; wq; scl = 1'b1; wq; m_low = 1'b1; wq; scl = 1'b0; wq;
  endtask

  task automatic i2c_stop;
    m_low = 1'b1; wq; scl = 1'b1; wq; m_low = 1'b0; wq; wq;
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; wq; scl = 1'b1; wq; wq; scl = 1'b0; wq;
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; wq; scl = 1'b1; wq; b = sda; wq; scl = 1'b0; wq;
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = (b == 1'b0);
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(last);
  endtask

  task automatic do_write(input logic [7:0] p, input int n, input string tag);
    logic [7:0] a;
    bit ack, dead, ex;
    a = em[20] & 8'hFE;
    dead = 1'b0;
    i2c_start;
    send_byte(a, ack);
    chk("R1 address ack", {7'b0, ack}, 8'd1);
    send_byte(p, ack);
    chk("R2 pointer ack", {7'b0, ack}, 8'd1);
    ep = p;
    for (int i = 0; i < n; i++) begin
      ex = !dead && ep != 8'd0 && ep < 8'd21;
      send_byte(wbuf[i], ack);
      chk(tag, {7'b0, ack}, {7'b0, ex});
      if (ex) begin
        model_wr(ep, wbuf[i]);
        ep = pinc(ep);
      end else begin
        if (!dead && ep == 8'd0) model_reset(cs_pin);
        dead = 1'b1;
      end
    end
    i2c_stop;
  endtask

  task automatic do_read(input logic [7:0] p, input int n, input string tag);
    logic [7:0] a, d;
    bit ack;
    a = em[20] & 8'hFE;
    i2c_start;
    send_byte(a, ack);
    chk("R1 address ack", {7'b0, ack}, 8'd1);
    send_byte(p, ack);
    chk("R2 pointer ack", {7'b0, ack}, 8'd1);
    ep = p;
    i2c_start;
    send_byte(a | 8'h01, ack);
    chk("R7 read address ack", {7'b0, ack}, 8'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, d);
      chk(tag, d, mread(ep));
      ep = pinc(ep);
    end
    i2c_stop;
    chk("R10 sda released", {7'b0, sda}, 8'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] p;
    int n;
    void'($urandom(32'd2024));
    hard_reset(1'b1);
    check_map("R4 R11 defaults cs=1");
    chk("R4 address with cs=1", regs_o[8*20 +: 8], 8'h56);
    hard_reset(1'b0);
    check_map("R4 defaults cs=0");
    hard_reset(1'b1);

    i2c_start;
    send_byte((em[20] ^ 8'h80) & 8'hFE, ack);
    chk("R1 foreign address nack", {7'b0, ack}, 8'd0);
    send_byte(8'h03, ack);
    send_byte(8'h5A, ack);
    chk("R1 ignored after foreign address", {7'b0, ack}, 8'd0);
    i2c_stop;
    check_map("R1 map untouched");

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(8'h02, 4, "R2 data ack");
    check_map("R2 burst stored");
    wbuf[0] = 8'h9C; wbuf[1] = 8'h07;
    do_write(8'h08, 2, "R3 data ack");
    check_map("R3 second burst");
    do_read(8'h02, 4, "R3 earlier burst kept");

    stat_sys = 3'd5; stat_ch = 8'hA5;
    do_read(8'h00, 3, "R7 status read");

    for (int i = 0; i < 8; i++) wbuf[i] = 8'hFF;
    do_write(8'h09, 8, "R6 data ack");
    check_map("R6 masks");
    do_read(8'h0B, 1, "R6 reserved 0Bh");
    do_read(8'h12, 2, "R6 reserved 12h 13h");

    wbuf[0] = 8'h3C; wbuf[1] = 8'h41; wbuf[2] = 8'h42;
    do_write(8'h14, 3, "R8 end of map ack");
    check_map("R8 nothing past end");
    do_read(8'h13, 4, "R8 read past end");

    wbuf[0] = 8'h30;
    do_write(8'h14, 1, "R9 locked write ack");
    check_map("R9 locked address kept");
    wbuf[0] = 8'hAB; wbuf[1] = 8'h31;
    do_write(8'h13, 2, "R9 unlock write ack");
    chk("R9 new address stored", regs_o[8*20 +: 8], 8'h30);
    i2c_start;
    send_byte(8'h56, ack);
    chk("R9 old address refused", {7'b0, ack}, 8'd0);
    i2c_stop;
    do_read(8'h14, 1, "R9 read via new address");
    wbuf[0] = 8'hAB;
    do_write(8'h13, 1, "R9 unlock");
    wbuf[0] = 8'h5A;
    do_write(8'h05, 1, "R9 other write");
    wbuf[0] = 8'h40;
    do_write(8'h14, 1, "R9 cancelled unlock");
    check_map("R9 unlock cancelled");

    wbuf[0] = 8'h77;
    do_write(8'h03, 1, "R5 setup");
    wbuf[0] = 8'h12; wbuf[1] = 8'h34;
    do_write(8'h00, 2, "R5 soft reset nack");
    check_map("R5 soft reset defaults");

    for (int it = 0; it < 16; it++) begin
      p = 8'(2 + $urandom_range(18, 0));
      n = $urandom_range(4, 1);
      for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
      if ($urandom_range(3, 0) == 0) begin
        p = 8'h13;
        wbuf[0] = 8'hAB;
      end
      do_write(p, n, "R2 random data ack");
      stat_sys = 3'($urandom);
      stat_ch = 8'($urandom);
      if (it % 4 == 3) do_read(8'h00, 23, "R7 full map read");
      else do_read(p, 3, "R7 random read");
      check_map("R11 random map");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule